// File: doc/BRIEF.md
# Battery Charge Counter with Capacity Learning

This block keeps the running charge account of a rechargeable battery. Three 16-bit values are held: the available capacity, a discharge tally, and a learned full-capacity reference. Compensated single-cycle count pulses arrive from outside. Charge pulses raise the available capacity, and discharge and self-discharge pulses lower it. An end-of-discharge event from a voltage monitor marks the battery as empty.

The learned reference starts at a programmed full count. It is replaced by the discharge tally only after a qualified discharge from full to empty, and one replacement may lower it by no more than a quarter. Three status flags are produced:

- a valid-discharge flag, which qualifies a learning cycle;
- a battery-replaced flag;
- a charge-status flag.

Surrounding logic reads these flags for display and for host reporting.

Top module: `charge_tracker`

## Requirements
- R1: A charge pulse raises `avail_cnt` by one, but never above `full_ref`. At `full_ref` the pulse has no effect.
- R2: A discharge pulse lowers `avail_cnt` by one. A self-discharge pulse does the same. Neither takes `avail_cnt` below zero.
- R3: While `avail_cnt` is non-zero, both discharge and self-discharge pulses raise `dsg_cnt`. At `avail_cnt` = 0, only discharge pulses raise it.
- R4: `dsg_cnt` stops at 65535 instead of wrapping. Any cycle that starts with `avail_cnt` = `full_ref` restarts the tally from zero before that cycle's pulse is counted.
- R5: A high `chg_done` loads `avail_cnt` with `full_ref` and sets `flag_vdis` on the next clock.
- R6: A discharge pulse in a cycle that starts with `avail_cnt` = `full_ref` sets `flag_vdis`.
- R7: `flag_vdis` is cleared by any of the following. Clear conditions override set conditions.
  - a valid charge;
  - `eod_evt` while `cold` is high;
  - more than 6% of the capacity held at set time removed by self-discharge since the flag was set;
  - reset.
- R8: A charge becomes valid on the third charge pulse that arrives while `chg_act` stays high with no discharge pulse in between. `flag_chg` rises at that pulse. It falls when `chg_act` goes low or when a discharge pulse arrives.
- R9: When charge and discharge pulses arrive in the same cycle, the discharge pulse alone is applied. When discharge and self-discharge pulses coincide, the self-discharge pulse is dropped.
- R10: The first valid charge after `eod_evt` clears `avail_cnt` to zero. If `flag_vdis` is set in that cycle, the same charge also writes `full_ref` with the larger of two values: `dsg_cnt`, or `full_ref` minus one quarter of `full_ref`.
- R11: Reset can come from `rst_n` low or `soft_rst` high, and is synchronous. It loads `full_ref` from `full_prog`. It clears `avail_cnt`, `dsg_cnt`, `flag_vdis` and `flag_chg`, and sets `flag_repl`.
- R12: `flag_repl` clears on the clock after a cycle in which `flag_chg` is high and `avail_cnt` equals `full_ref`. It also clears on a valid charge that follows `eod_evt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| soft_rst | input | 1 | Synchronous reset command, active high |
| full_prog | input | 16 | Programmed full count, loaded into `full_ref` on reset |
| chg_pulse | input | 1 | One compensated charge count |
| dsg_pulse | input | 1 | One compensated discharge count |
| sdsg_pulse | input | 1 | One self-discharge count |
| chg_act | input | 1 | Level: charge activity is present |
| chg_done | input | 1 | Level: external charger reports full |
| eod_evt | input | 1 | End-of-discharge event pulse |
| cold | input | 1 | Level: temperature below 0 °C |
| avail_cnt | output | 16 | Available capacity |
| dsg_cnt | output | 16 | Discharge tally |
| full_ref | output | 16 | Learned full-capacity reference |
| flag_vdis | output | 1 | Valid-discharge flag |
| flag_repl | output | 1 | Battery-replaced flag |
| flag_chg | output | 1 | Charge-status flag |

## Verification
All state is registered straight onto the ports, so a wrong counter value appears on `avail_cnt`, `dsg_cnt` or `full_ref` on the clock edge after the offending pulse. A hidden fault stays invisible longer. A mis-tracked run counter, end-of-discharge memory or self-discharge accumulator shows only at the next qualifying event. That event is the third charge pulse, the transfer into `full_ref`, or the self-discharge pulse that crosses the 6% limit. The bench therefore drives each hidden path up to that event and checks the ports on the very next cycle.

// File: rtl/chgtrk_pkg.sv
// Shared constants for the charge tracker.
// Assumes: counters are unsigned; the self-discharge limit is expressed
// as the ratio SD_NUM/SD_DEN of the capacity captured at flag set time.
package chgtrk_pkg;
    localparam int CNT_W      = 16;
    localparam int VALID_RUNS = 2;   // pulses that must precede the qualifying one
    localparam int SD_NUM     = 3;   // 3/50 = 6 %
    localparam int SD_DEN     = 50;
endpackage

// File: rtl/cap_counter.sv
// Available-capacity counter and discharge tally.
// Does: applies one pulse per cycle by priority. The order is: charge-complete
// load, post-empty clear, discharge, self-discharge, charge.
// Assumes: full_ref is the registered learned reference; xfer is the
// single-cycle "valid charge after empty" strobe.
module cap_counter #(
    parameter int W = chgtrk_pkg::CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         soft_rst,
    input  logic         chg_pulse,
    input  logic         dsg_pulse,
    input  logic         sdsg_pulse,
    input  logic         chg_done,
    input  logic         xfer,
    input  logic [W-1:0] full_ref,
    output logic [W-1:0] avail_q,
    output logic [W-1:0] dcnt_q,
    output logic         sd_dec
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};

    logic         at_full;
    logic [W-1:0] dbase;
    logic [W-1:0] avail_d;
    logic [W-1:0] dcnt_d;

    // Pick the single pulse that acts this cycle and form next values.
    always_comb begin
        at_full = (avail_q == full_ref);
        dbase   = at_full ? '0 : dcnt_q;
        avail_d = avail_q;
        dcnt_d  = dbase;
        sd_dec  = 1'b0;
        if (chg_done) begin
            avail_d = full_ref;
        end else if (xfer) begin
            avail_d = '0;
        end else if (dsg_pulse) begin
            avail_d = (avail_q == '0) ? '0 : avail_q - 1'b1;
            dcnt_d  = (dbase == MAXV) ? MAXV : dbase + 1'b1;
        end else if (sdsg_pulse && avail_q != '0) begin
            avail_d = avail_q - 1'b1;
            dcnt_d  = (dbase == MAXV) ? MAXV : dbase + 1'b1;
            sd_dec  = 1'b1;
        end else if (chg_pulse && avail_q < full_ref) begin
            avail_d = avail_q + 1'b1;
        end
    end

    // Register both counters; either reset source clears them.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            avail_q <= '0;
            dcnt_q  <= '0;
        end else begin
            avail_q <= avail_d;
            dcnt_q  <= dcnt_d;
        end
    end

    // R1
    avail_le_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        avail_q <= full_ref);

    // R4
    dcnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dcnt_q == MAXV && avail_q != full_ref && !soft_rst) |=> dcnt_q == MAXV);
endmodule

// File: rtl/learn_unit.sv
// Learned full-capacity reference.
// Does: loads the programmed count on reset. On a qualified transfer it takes
// the discharge tally, bounded below by three quarters of the old value.
// Assumes: xfer and vdis are sampled in the same cycle, before the flag clears.
module learn_unit #(
    parameter int W = chgtrk_pkg::CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         soft_rst,
    input  logic [W-1:0] full_prog,
    input  logic         xfer,
    input  logic         vdis,
    input  logic [W-1:0] dcnt,
    output logic [W-1:0] learned_q
);
    logic [W-1:0] floor_v;

    // Lowest value a single transfer may write.
    always_comb floor_v = learned_q - (learned_q >> 2);

    // Hold, reload or transfer the reference.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst)
            learned_q <= full_prog;
        else if (xfer && vdis)
            learned_q <= (dcnt >= floor_v) ? dcnt : floor_v;
    end

    // R10
    quarter_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !soft_rst |=> ({1'b0, learned_q} + {1'b0, ($past(learned_q) >> 2)})
                      >= {1'b0, $past(learned_q)});
endmodule

// File: rtl/flag_unit.sv
// Charge qualification and status flags.
// Does: qualifies a valid charge from a run of charge pulses and remembers a
// pending end-of-discharge. Keeps the valid-discharge, replaced and
// charge-status flags, plus the self-discharge budget behind the
// valid-discharge flag.
// Assumes: sd_dec marks a self-discharge pulse that actually lowered capacity.
module flag_unit #(
    parameter int W = chgtrk_pkg::CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         soft_rst,
    input  logic         chg_pulse,
    input  logic         dsg_pulse,
    input  logic         chg_act,
    input  logic         chg_done,
    input  logic         eod_evt,
    input  logic         cold,
    input  logic         sd_dec,
    input  logic [W-1:0] avail,
    input  logic [W-1:0] full_ref,
    output logic         xfer,
    output logic         vdis_q,
    output logic         repl_q,
    output logic         chg_q
);
    localparam int PW = W + 7;
    localparam int RUN_MAX = chgtrk_pkg::VALID_RUNS + 1;

    logic [1:0]    run_q;
    logic          eod_pend_q;
    logic [W-1:0]  snap_q;
    logic [W-1:0]  sd_acc_q;
    logic          chg_step;
    logic          valid_evt;
    logic          sd_over;
    logic          vd_kill;
    logic          vd_set;
    logic [PW-1:0] lhs;
    logic [PW-1:0] rhs;

    // Decode events for this cycle.
    always_comb begin
        chg_step  = chg_pulse && chg_act && !dsg_pulse;
        valid_evt = chg_step && (run_q == 2'(chgtrk_pkg::VALID_RUNS));
        xfer      = valid_evt && eod_pend_q;
        lhs       = (PW'(sd_acc_q) + PW'(1)) * PW'(chgtrk_pkg::SD_DEN);
        rhs       = PW'(snap_q) * PW'(chgtrk_pkg::SD_NUM);
        sd_over   = sd_dec && vdis_q && (lhs > rhs);
        vd_kill   = valid_evt || (eod_evt && cold) || sd_over;
        vd_set    = chg_done || (dsg_pulse && avail == full_ref);
    end

    // Run length of uninterrupted charge pulses, saturating past the threshold.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst || !chg_act || dsg_pulse)
            run_q <= '0;
        else if (chg_step && run_q != 2'(RUN_MAX))
            run_q <= run_q + 1'b1;
    end

    // Remember an end-of-discharge until the next valid charge.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst)
            eod_pend_q <= 1'b0;
        else if (eod_evt)
            eod_pend_q <= 1'b1;
        else if (valid_evt)
            eod_pend_q <= 1'b0;
    end

    // Charge-status flag.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst || !chg_act || dsg_pulse)
            chg_q <= 1'b0;
        else if (valid_evt)
            chg_q <= 1'b1;
    end

    // Battery-replaced flag.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst)
            repl_q <= 1'b1;
        else if (xfer || (chg_q && avail == full_ref))
            repl_q <= 1'b0;
    end

    // Valid-discharge flag with its self-discharge budget; clears beat sets.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            vdis_q   <= 1'b0;
            snap_q   <= '0;
            sd_acc_q <= '0;
        end else if (vd_kill) begin
            vdis_q   <= 1'b0;
        end else if (vd_set) begin
            vdis_q   <= 1'b1;
            snap_q   <= chg_done ? full_ref : avail;
            sd_acc_q <= '0;
        end else if (sd_dec && vdis_q) begin
            sd_acc_q <= sd_acc_q + 1'b1;
        end
    end

    // R7
    cold_eod_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eod_evt && cold) |=> !vdis_q);

    // R8
    chg_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!chg_act || dsg_pulse) |=> !chg_q);

    // R11
    soft_reset_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (repl_q && !vdis_q && !chg_q));
endmodule

// File: rtl/charge_tracker.sv
// Top of the battery charge counter.
// Does: connects the capacity counter, the learned reference and the flag
// logic; every output is a register.
// Assumes: input pulses are single-cycle and already compensated.
module charge_tracker #(
    parameter int W = chgtrk_pkg::CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         soft_rst,
    input  logic [W-1:0] full_prog,
    input  logic         chg_pulse,
    input  logic         dsg_pulse,
    input  logic         sdsg_pulse,
    input  logic         chg_act,
    input  logic         chg_done,
    input  logic         eod_evt,
    input  logic         cold,
    output logic [W-1:0] avail_cnt,
    output logic [W-1:0] dsg_cnt,
    output logic [W-1:0] full_ref,
    output logic         flag_vdis,
    output logic         flag_repl,
    output logic         flag_chg
);
    logic xfer;
    logic sd_dec;

    cap_counter #(.W(W)) u_cap (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .chg_pulse(chg_pulse), .dsg_pulse(dsg_pulse), .sdsg_pulse(sdsg_pulse),
        .chg_done(chg_done), .xfer(xfer), .full_ref(full_ref),
        .avail_q(avail_cnt), .dcnt_q(dsg_cnt), .sd_dec(sd_dec)
    );

    learn_unit #(.W(W)) u_learn (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .full_prog(full_prog), .xfer(xfer), .vdis(flag_vdis),
        .dcnt(dsg_cnt), .learned_q(full_ref)
    );

    flag_unit #(.W(W)) u_flags (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .chg_pulse(chg_pulse), .dsg_pulse(dsg_pulse), .chg_act(chg_act),
        .chg_done(chg_done), .eod_evt(eod_evt), .cold(cold),
        .sd_dec(sd_dec), .avail(avail_cnt), .full_ref(full_ref),
        .xfer(xfer), .vdis_q(flag_vdis), .repl_q(flag_repl), .chg_q(flag_chg)
    );
endmodule

// File: tb/tb_charge_tracker.sv
`timescale 1ns/1ps
module tb_charge_tracker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic [15:0] full_prog = 16'd8;
    logic        chg_pulse = 0, dsg_pulse = 0, sdsg_pulse = 0;
    logic        chg_act = 0, chg_done = 0, eod_evt = 0, cold = 0;
    logic [15:0] avail_cnt, dsg_cnt, full_ref;
    logic        flag_vdis, flag_repl, flag_chg;
    int          n_vec = 0;
    int          n_bad = 0;

    always #2.5 clk = ~clk;

    charge_tracker dut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .full_prog(full_prog),
        .chg_pulse(chg_pulse), .dsg_pulse(dsg_pulse), .sdsg_pulse(sdsg_pulse),
        .chg_act(chg_act), .chg_done(chg_done), .eod_evt(eod_evt), .cold(cold),
        .avail_cnt(avail_cnt), .dsg_cnt(dsg_cnt), .full_ref(full_ref),
        .flag_vdis(flag_vdis), .flag_repl(flag_repl), .flag_chg(flag_chg)
    );

    // Input bits {act,cold,eod,done,sdsg,dsg,chg}; then avail, dsg_cnt, full_ref, {vdis,repl,chg}
    localparam logic [57:0] VEC [24] = '{
        {7'b1000001, 16'd1, 16'd0, 16'd8, 3'b010},  // R8 run 1, no valid yet
        {7'b1000001, 16'd2, 16'd0, 16'd8, 3'b010},  // R8 run 2
        {7'b1000001, 16'd3, 16'd0, 16'd8, 3'b011},  // R8 third pulse valid
        {7'b1000001, 16'd4, 16'd0, 16'd8, 3'b011},
        {7'b1000001, 16'd5, 16'd0, 16'd8, 3'b011},
        {7'b1000001, 16'd6, 16'd0, 16'd8, 3'b011},
        {7'b1000001, 16'd7, 16'd0, 16'd8, 3'b011},
        {7'b1000001, 16'd8, 16'd0, 16'd8, 3'b011},  // R1 reaches full
        {7'b1000001, 16'd8, 16'd0, 16'd8, 3'b001},  // R1 saturates, R12 repl clears
        {7'b0000000, 16'd8, 16'd0, 16'd8, 3'b000},  // R8 activity stops
        {7'b0000010, 16'd7, 16'd1, 16'd8, 3'b100},  // R6 set, R4 restart, R2
        {7'b0000010, 16'd6, 16'd2, 16'd8, 3'b100},
        {7'b0000011, 16'd5, 16'd3, 16'd8, 3'b100},  // R9 discharge wins
        {7'b0000010, 16'd4, 16'd4, 16'd8, 3'b100},
        {7'b0000010, 16'd3, 16'd5, 16'd8, 3'b100},
        {7'b0000010, 16'd2, 16'd6, 16'd8, 3'b100},
        {7'b0000010, 16'd1, 16'd7, 16'd8, 3'b100},
        {7'b0000010, 16'd0, 16'd8, 16'd8, 3'b100},
        {7'b0000010, 16'd0, 16'd9, 16'd8, 3'b100},  // R2 floor, R3 still counts
        {7'b0000100, 16'd0, 16'd9, 16'd8, 3'b100},  // R3 self-discharge at empty ignored
        {7'b0010000, 16'd0, 16'd9, 16'd8, 3'b100},  // R7 warm eod keeps flag
        {7'b1000001, 16'd1, 16'd9, 16'd8, 3'b100},
        {7'b1000001, 16'd2, 16'd9, 16'd8, 3'b100},
        {7'b1000001, 16'd0, 16'd9, 16'd9, 3'b001}   // R10 transfer, R7 clear
    };

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic drive(input logic [6:0] v);
        {chg_act, cold, eod_evt, chg_done, sdsg_pulse, dsg_pulse, chg_pulse} = v;
        @(posedge clk);
        #1;
        {chg_act, cold, eod_evt, chg_done, sdsg_pulse, dsg_pulse, chg_pulse} = '0;
    endtask

    task automatic hard_reset(input logic [15:0] fp);
        full_prog = fp;
        rst_n = 1'b0;
        @(posedge clk);
        @(posedge clk);
        #1;
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired (all requirements)");
        finish_run();
    end

    initial begin
        #1;
        // R11 reset state
        hard_reset(16'd8);
        chk("R11 avail", avail_cnt, 16'd0);
        chk("R11 dsg_cnt", dsg_cnt, 16'd0);
        chk("R11 full_ref", full_ref, 16'd8);
        chk("R11 flags", {13'd0, flag_vdis, flag_repl, flag_chg}, 16'b010);

        for (int i = 0; i < 24; i++) begin
            drive(VEC[i][57:51]);
            chk($sformatf("row%0d avail", i), avail_cnt, VEC[i][50:35]);
            chk($sformatf("row%0d dsg_cnt", i), dsg_cnt, VEC[i][34:19]);
            chk($sformatf("row%0d full_ref", i), full_ref, VEC[i][18:3]);
            chk($sformatf("row%0d flags", i), {13'd0, flag_vdis, flag_repl, flag_chg},
                {13'd0, VEC[i][2:0]});
        end

        // R10 quarter limit on a low tally; R12 replaced flag clears after empty
        hard_reset(16'd100);
        drive(7'b0001000);
        chk("R5 done load", avail_cnt, 16'd100);
        chk("R5 done sets vdis", {15'd0, flag_vdis}, 16'd1);
        for (int k = 0; k < 10; k++) drive(7'b0000010);
        chk("R2 avail after 10", avail_cnt, 16'd90);
        chk("R3 dsg_cnt after 10", dsg_cnt, 16'd10);
        drive(7'b0010000);
        for (int k = 0; k < 3; k++) drive(7'b1000001);
        chk("R10 quarter limit", full_ref, 16'd75);
        chk("R10 avail cleared", avail_cnt, 16'd0);
        chk("R12 repl after eod", {15'd0, flag_repl}, 16'd0);
        chk("R7 valid charge clears", {15'd0, flag_vdis}, 16'd0);

        // R7 six percent self-discharge budget
        hard_reset(16'd100);
        drive(7'b0001000);
        for (int k = 0; k < 6; k++) drive(7'b0000100);
        chk("R7 within budget", {15'd0, flag_vdis}, 16'd1);
        chk("R2 self-discharge", avail_cnt, 16'd94);
        chk("R3 self-discharge counts", dsg_cnt, 16'd6);
        drive(7'b0000100);
        chk("R7 budget exceeded", {15'd0, flag_vdis}, 16'd0);

        // R7 cold end-of-discharge
        hard_reset(16'd100);
        drive(7'b0001000);
        drive(7'b0110000);
        chk("R7 cold eod", {15'd0, flag_vdis}, 16'd0);

        // R4 saturation of the tally
        hard_reset(16'd8);
        for (int k = 0; k < 65536; k++) drive(7'b0000010);
        chk("R4 saturate", dsg_cnt, 16'hFFFF);
        chk("R2 floor", avail_cnt, 16'd0);

        // R11 soft reset
        full_prog = 16'd20;
        soft_rst = 1'b1;
        @(posedge clk);
        #1;
        soft_rst = 1'b0;
        chk("R11 soft full_ref", full_ref, 16'd20);
        chk("R11 soft dsg_cnt", dsg_cnt, 16'd0);
        chk("R11 soft flags", {13'd0, flag_vdis, flag_repl, flag_chg}, 16'b010);

        finish_run();
    end
endmodule